// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block watches a table of in-flight memory requests and raises an alarm when one of them has waited too long. Whenever the owning logic allocates an entry, the block stamps that entry with the value of a free-running cycle counter. It clears the stamp's valid bit when the entry is retired. The age of an entry is the present counter value minus its stamp, taken modulo the counter width.

The age test is not continuous. The first allocation made while no test is pending arms a test one threshold period ahead. Each test examines every live entry in a single cycle. The read-side entries and the write-side entries are examined alike. After a test, the next one is armed one threshold later, but only while entries are still live. A test that finds an entry whose age has reached the threshold sets a sticky deadlock flag. The flag reports the lowest-numbered such entry and its age. The same test also compares the table's own outstanding count against the number of live stamps, and a disagreement sets a separate sticky flag.

Top module: `wd_deadlock_watchdog`

## Requirements
- R1: After reset, `checkStrobe`, `deadlockErr`, `countErr`, `errIdx` and `errAge` are all zero, and no test is pending.
- R2: An allocation made while no test is pending arms a test. `checkStrobe` is high in the cycle in which the cycle counter equals the allocation's stamp plus `threshold`.
- R3: After a test, another test is armed `threshold` cycles later if at least one entry is live or an allocation arrives in that cycle. Otherwise, no further test occurs until the next allocation.
- R4: The age of an entry is the counter value minus its stamp. A test in which a live entry has an age of at least `threshold` sets `deadlockErr` on the following clock edge. An entry whose age is `threshold`-1 does not set it.
- R5: When several entries have expired, `errIdx` reports the lowest-numbered one. `errAge` reports that entry's age as evaluated in the test cycle.
- R6: Indices 0 to RD_N-1 are read-side entries and indices RD_N to RD_N+WR_N-1 are write-side entries. Both ranges are examined by every test.
- R7: `deadlockErr`, `errIdx` and `errAge` hold their values until reset, whatever later tests find.
- R8: A test in which `outstandCnt` differs from the number of live entries sets the sticky `countErr` on the following edge.
- R9: An entry retired through `relValid`/`relIdx` is not examined, even though its stamp is older than any live stamp.
- R10: Age arithmetic stays correct when the counter wraps past zero, provided that `threshold` is below half the counter range.
- R11: An allocation made while a test is already pending does not move that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Entry allocated this cycle |
| insIdx | input | IDX_W | Index of the allocated entry |
| relValid | input | 1 | Entry retired this cycle |
| relIdx | input | IDX_W | Index of the retired entry |
| outstandCnt | input | CNT_W | Outstanding count kept by the request table |
| threshold | input | TS_W | Age limit in cycles, greater than zero |
| checkStrobe | output | 1 | High in the cycle a test is evaluated |
| deadlockErr | output | 1 | Sticky: an entry reached the age limit |
| errIdx | output | IDX_W | Lowest expired entry at the first failing test |
| errAge | output | TS_W | Age of that entry at that test |
| countErr | output | 1 | Sticky: count disagreement seen at a test |

## Verification
On every cycle, the assertions check the following. Both flags, once set, stay set, and the reported index and age do not move. The deadlock flag can rise only right after a test cycle, with a reported age no smaller than the threshold. Two tests are never adjacent when the threshold exceeds one. The bench scenarios are needed to show the following: exact test timing relative to allocations, stopping once the table drains, lowest-index selection among several expired entries, exclusion of retired entries, and age arithmetic across counter wrap.

// File: rtl/wd_pkg.sv
package wd_pkg;
  // Strobes driven from the scheduling control into the age datapath.
  typedef struct packed {
    logic runCheck;
  } wdStrobe_t;
endpackage

// File: rtl/wd_control.sv
module wd_control
  import wd_pkg::*;
#(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            insValid,
  input  logic            anyLive,
  input  logic [TS_W-1:0] threshold,
  input  logic [TS_W-1:0] nowCycle,
  output wdStrobe_t       strobe
);
  logic            pending;
  logic [TS_W-1:0] nextCheck;
  logic            fireNow;

  assign fireNow = pending && (nowCycle == nextCheck);
  assign strobe.runCheck = fireNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      nextCheck <= '0;
    end else if (fireNow) begin
      // re-arm only while requests remain (or one arrives now)
      pending   <= anyLive || insValid;
      nextCheck <= nowCycle + threshold;
    end else if (insValid && !pending) begin
      pending   <= 1'b1;
      nextCheck <= nowCycle + threshold;
    end
  end

  // R3
  no_adjacent_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fireNow && threshold > 1) |=> !fireNow);
endmodule

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int RD_N = 4,
  parameter int WR_N = 4,
  parameter int TS_W = 8,
  localparam int ENT_N = RD_N + WR_N,
  localparam int IDX_W = $clog2(ENT_N),
  localparam int CNT_W = $clog2(ENT_N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic [IDX_W-1:0] insIdx,
  input  logic             relValid,
  input  logic [IDX_W-1:0] relIdx,
  input  logic [CNT_W-1:0] outstandCnt,
  input  logic [TS_W-1:0]  threshold,
  input  wdStrobe_t        strobe,
  output logic [TS_W-1:0]  nowCycle,
  output logic             anyLive,
  output logic             deadlockErr,
  output logic [IDX_W-1:0] errIdx,
  output logic [TS_W-1:0]  errAge,
  output logic             countErr
);
  logic [ENT_N-1:0] liveVec;
  logic [ENT_N-1:0] expiredVec;
  logic [TS_W-1:0]  ageVec [ENT_N];
  logic [CNT_W-1:0] liveCount;
  logic             anyExpired;
  logic [IDX_W-1:0] firstIdx;
  logic [TS_W-1:0]  firstAge;

  // Free-running cycle counter, wraps modulo 2**TS_W.
  always_ff @(posedge clk) begin
    if (!rstN) nowCycle <= '0;
    else       nowCycle <= nowCycle + 1'b1;
  end

  // Per-entry stamp storage and parallel age comparators.
  for (genvar g = 0; g < ENT_N; g++) begin : g_entry
    logic [TS_W-1:0] stamp;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveVec[g] <= 1'b0;
        stamp      <= '0;
      end else if (insValid && insIdx == IDX_W'(g)) begin
        liveVec[g] <= 1'b1;
        stamp      <= nowCycle;
      end else if (relValid && relIdx == IDX_W'(g)) begin
        liveVec[g] <= 1'b0;
      end
    end
    assign ageVec[g]     = nowCycle - stamp;
    assign expiredVec[g] = liveVec[g] && (ageVec[g] >= threshold);
  end

  // Lowest expired index wins: scan from the top down.
  always_comb begin
    anyExpired = 1'b0;
    firstIdx   = '0;
    firstAge   = '0;
    for (int i = ENT_N - 1; i >= 0; i--) begin
      if (expiredVec[i]) begin
        anyExpired = 1'b1;
        firstIdx   = IDX_W'(i);
        firstAge   = ageVec[i];
      end
    end
  end

  always_comb begin
    liveCount = '0;
    for (int i = 0; i < ENT_N; i++) liveCount = liveCount + CNT_W'(liveVec[i]);
  end
  assign anyLive = |liveVec;

  // Sticky reporting registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      deadlockErr <= 1'b0;
      errIdx      <= '0;
      errAge      <= '0;
      countErr    <= 1'b0;
    end else if (strobe.runCheck) begin
      if (!deadlockErr && anyExpired) begin
        deadlockErr <= 1'b1;
        errIdx      <= firstIdx;
        errAge      <= firstAge;
      end
      if (outstandCnt != liveCount) countErr <= 1'b1;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    deadlockErr |=> (deadlockErr && $stable(errIdx) && $stable(errAge)));
  // R8
  cnt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    countErr |=> countErr);
  // R4
  err_after_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deadlockErr) |-> $past(strobe.runCheck));
  // R5
  err_age_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(deadlockErr) && $stable(threshold)) |-> (errAge >= threshold));
endmodule

// File: rtl/wd_deadlock_watchdog.sv
module wd_deadlock_watchdog
  import wd_pkg::*;
#(
  parameter int RD_N = 4,
  parameter int WR_N = 4,
  parameter int TS_W = 8,
  localparam int ENT_N = RD_N + WR_N,
  localparam int IDX_W = $clog2(ENT_N),
  localparam int CNT_W = $clog2(ENT_N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic [IDX_W-1:0] insIdx,
  input  logic             relValid,
  input  logic [IDX_W-1:0] relIdx,
  input  logic [CNT_W-1:0] outstandCnt,
  input  logic [TS_W-1:0]  threshold,
  output logic             checkStrobe,
  output logic             deadlockErr,
  output logic [IDX_W-1:0] errIdx,
  output logic [TS_W-1:0]  errAge,
  output logic             countErr
);
  wdStrobe_t       strobe;
  logic [TS_W-1:0] nowCycle;
  logic            anyLive;

  wd_control #(.TS_W(TS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .anyLive(anyLive),
    .threshold(threshold), .nowCycle(nowCycle), .strobe(strobe)
  );

  wd_datapath #(.RD_N(RD_N), .WR_N(WR_N), .TS_W(TS_W)) u_dp (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insIdx(insIdx),
    .relValid(relValid), .relIdx(relIdx), .outstandCnt(outstandCnt),
    .threshold(threshold), .strobe(strobe), .nowCycle(nowCycle),
    .anyLive(anyLive), .deadlockErr(deadlockErr), .errIdx(errIdx),
    .errAge(errAge), .countErr(countErr)
  );

  assign checkStrobe = strobe.runCheck;
endmodule

// File: tb/wd_deadlock_watchdog_tb.sv
`timescale 1ns/1ps
module wd_deadlock_watchdog_tb;
  localparam int RD_N = 4, WR_N = 4, TS_W = 8;
  localparam int ENT_N = RD_N + WR_N;
  localparam int IDX_W = $clog2(ENT_N);
  localparam int CNT_W = $clog2(ENT_N + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic insValid = 0, relValid = 0;
  logic [IDX_W-1:0] insIdx = '0, relIdx = '0;
  logic [CNT_W-1:0] outstandCnt = '0;
  logic [TS_W-1:0]  threshold = 8'd10;
  logic checkStrobe, deadlockErr, countErr;
  logic [IDX_W-1:0] errIdx;
  logic [TS_W-1:0]  errAge;

  int checks = 0, errors = 0, cycles = 0, cntSkew = 0;
  bit compareOn = 0;

  always #2.5 clk = ~clk;

  wd_deadlock_watchdog #(.RD_N(RD_N), .WR_N(WR_N), .TS_W(TS_W)) u_dut (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insIdx(insIdx),
    .relValid(relValid), .relIdx(relIdx), .outstandCnt(outstandCnt),
    .threshold(threshold), .checkStrobe(checkStrobe), .deadlockErr(deadlockErr),
    .errIdx(errIdx), .errAge(errAge), .countErr(countErr)
  );

  // ---------------- reference model from the requirements ----------------
  logic            mValid [ENT_N];
  logic [TS_W-1:0] mTs [ENT_N];
  logic [TS_W-1:0] mNow, mNext, mAge;
  logic            mPend, mErr, mCntErr;
  logic [IDX_W-1:0] mIdx;

  function automatic int livePop();
    int n = 0;
    for (int i = 0; i < ENT_N; i++) n += int'(mValid[i]);
    return n;
  endfunction

  function automatic logic expFire();
    return mPend && (mNow == mNext);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENT_N; i++) begin mValid[i] = 0; mTs[i] = '0; end
      mNow = '0; mNext = '0; mPend = 0; mErr = 0; mCntErr = 0; mIdx = '0; mAge = '0;
    end else begin
      logic fire, hit;
      logic [IDX_W-1:0] hIdx;
      logic [TS_W-1:0] hAge, a;
      int pop;
      fire = expFire();
      pop = livePop();
      hit = 0; hIdx = '0; hAge = '0;
      for (int i = ENT_N - 1; i >= 0; i--) begin
        a = mNow - mTs[i];
        if (mValid[i] && a >= threshold) begin hit = 1; hIdx = IDX_W'(i); hAge = a; end
      end
      if (fire) begin
        if (!mErr && hit) begin mErr = 1; mIdx = hIdx; mAge = hAge; end
        if (int'(outstandCnt) != pop) mCntErr = 1;
        mPend = (pop != 0) || insValid;
        mNext = mNow + threshold;
      end else if (insValid && !mPend) begin
        mPend = 1; mNext = mNow + threshold;
      end
      if (insValid) begin mValid[insIdx] = 1; mTs[insIdx] = mNow; end
      if (relValid && !(insValid && insIdx == relIdx)) mValid[relIdx] = 0;
      mNow = mNow + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && compareOn) begin
      chk("R2/R3 strobe timing", 32'(checkStrobe), 32'(expFire()));
      chk("R4 deadlock flag", 32'(deadlockErr), 32'(mErr));
      chk("R5 reported index", 32'(errIdx), 32'(mIdx));
      chk("R5 reported age", 32'(errAge), 32'(mAge));
      chk("R8 count flag", 32'(countErr), 32'(mCntErr));
    end
  end

  // ---------------- stimulus helpers (start and end at a negedge) --------
  task automatic step(input logic iv, input int ii, input logic rv, input int ri);
    insValid = iv; insIdx = IDX_W'(ii);
    relValid = rv; relIdx = IDX_W'(ri);
    outstandCnt = CNT_W'(livePop() + cntSkew);
    @(negedge clk);
    cycles++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  task automatic doReset(input int thr);
    @(negedge clk);
    rstN = 0; insValid = 0; relValid = 0; cntSkew = 0;
    threshold = TS_W'(thr);
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  int sCount;

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    compareOn = 1;

    // R1: reset state
    doReset(12);
    chk("R1 strobe", 32'(checkStrobe), 0);
    chk("R1 deadlock", 32'(deadlockErr), 0);
    chk("R1 count flag", 32'(countErr), 0);
    chk("R1 index", 32'(errIdx), 0);
    chk("R1 age", 32'(errAge), 0);

    // R2, R4, R6 (write entry 4), R3 re-arm, R7 sticky
    step(1, 4, 0, 0);
    idle(12 - 2);
    chk("R2 no early test", 32'(checkStrobe), 0);
    chk("R4 age thr-1 no flag", 32'(deadlockErr), 0);
    idle(1);
    chk("R2 test at stamp+thr", 32'(checkStrobe), 1);
    idle(1);
    chk("R4 flag set", 32'(deadlockErr), 1);
    chk("R6 write-side index", 32'(errIdx), 4);
    chk("R5 age", 32'(errAge), 12);
    idle(12 - 2);
    chk("R3 no early re-test", 32'(checkStrobe), 0);
    idle(1);
    chk("R3 re-test while live", 32'(checkStrobe), 1);
    step(1, 0, 0, 0);
    chk("R7 flag held", 32'(deadlockErr), 1);
    chk("R7 index held", 32'(errIdx), 4);
    chk("R7 age held", 32'(errAge), 12);

    // R5 lowest index, R9 retired entry excluded
    doReset(20);
    step(1, 6, 0, 0);
    step(1, 5, 0, 0);
    step(1, 1, 0, 0);
    step(1, 3, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 6);
    idle(14);
    chk("R2 first test", 32'(checkStrobe), 1);
    idle(1);
    chk("R4 nothing expired yet", 32'(deadlockErr), 0);
    idle(19);
    chk("R3 second test", 32'(checkStrobe), 1);
    idle(1);
    chk("R5 flag", 32'(deadlockErr), 1);
    chk("R9 retired entry 1 skipped, R5 lowest is 3", 32'(errIdx), 3);
    chk("R5 age of entry 3", 32'(errAge), 37);

    // R3 stop when drained, R2 re-arm by a later allocation, R6 read side
    doReset(15);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    idle(12);
    chk("R3 test runs once", 32'(checkStrobe), 1);
    sCount = 0;
    for (int k = 0; k < 40; k++) begin idle(1); sCount += int'(checkStrobe); end
    chk("R3 no test after drain", 32'(sCount), 0);
    step(1, 2, 0, 0);
    idle(14);
    chk("R2 re-armed by allocation", 32'(checkStrobe), 1);
    idle(1);
    chk("R6 read-side index", 32'(errIdx), 2);
    chk("R4 age at limit flags", 32'(errAge), 15);

    // R8 count disagreement
    doReset(9);
    cntSkew = 1;
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    idle(7);
    chk("R8 test cycle", 32'(checkStrobe), 1);
    idle(1);
    chk("R8 count flag set", 32'(countErr), 1);
    chk("R8 no deadlock", 32'(deadlockErr), 0);
    cntSkew = 0;

    // R10 wrap
    doReset(100);
    idle(200);
    step(1, 7, 0, 0);
    idle(99);
    chk("R10 test across wrap", 32'(checkStrobe), 1);
    idle(1);
    chk("R10 flag", 32'(deadlockErr), 1);
    chk("R10 age across wrap", 32'(errAge), 100);

    // R11 allocation while pending does not move the test
    doReset(16);
    step(1, 0, 0, 0);
    idle(4);
    step(1, 1, 0, 0);
    idle(10);
    chk("R11 test keeps original time", 32'(checkStrobe), 1);
    idle(1);
    chk("R11 oldest flagged", 32'(errIdx), 0);

    // constrained random batches
    for (int b = 0; b < 6; b++) begin
      doReset(8 + int'($urandom % 40));
      for (int k = 0; k < 400; k++) begin
        int op = int'($urandom % 5);
        int st = int'($urandom % ENT_N);
        int pick = -1;
        if (op <= 1) begin
          for (int j = 0; j < ENT_N; j++)
            if (pick < 0 && !mValid[(st + j) % ENT_N]) pick = (st + j) % ENT_N;
          if (pick >= 0) step(1, pick, 0, 0); else idle(1);
        end else if (op == 2) begin
          for (int j = 0; j < ENT_N; j++)
            if (pick < 0 && mValid[(st + j) % ENT_N]) pick = (st + j) % ENT_N;
          if (pick >= 0) step(0, 0, 1, pick); else idle(1);
        end else idle(1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule